// File: doc/BRIEF.md
# Snooped Configuration Register Responder

This block sits on the client side of a host controller that watches configuration traffic. It holds a small bank of 32-bit configuration registers. When the controller sees a configuration write, it raises a one-cycle write strobe. The strobe carries the register number, the function number, the data word, the byte enables and the end-to-end parity bits for the data and the enables. If the access falls inside the block's register window, the block merges the enabled bytes into the addressed register.

When the controller sees a configuration read, it raises a one-cycle read strobe. On the next rising edge the block registers its answer. It drives a valid flag when it owns the register, together with the register contents and per-byte parity. The controller samples that answer on the following edge and uses it as the completion payload. With the valid flag low, the controller treats the register as not implemented here.

The window is a contiguous run of `NREGS` register numbers starting at `BASE`, and it answers for function 0 only. A write whose parity does not check is discarded, and it sets a sticky error flag that only reset clears.

Top module: `cfg_snoop_regs`

## Requirements
- R1: After reset, `rd_valid` is 0, `rd_data` is 0 and `par_err` is 0, and every register in the window reads back as 0.
- R2: A read strobe with function 0 and a register number in [BASE, BASE+NREGS-1] makes `rd_valid` 1 and `rd_data` equal to the register contents in the cycle after the strobe.
- R3: `rd_valid` and `rd_data` are nonzero only in the single cycle after an accepted read strobe. In every other cycle both are 0.
- R4: A read strobe with a nonzero function number, or with a register number outside the window, leaves `rd_valid` 0 and `rd_data` 0 in the following cycle.
- R5: A write updates only the bytes whose enable is set: `wr_be[b]` governs data bits 8b+7..8b. The other bytes keep their old values.
- R6: A write with a nonzero function number, or with a register number outside the window, changes no register.
- R7: Parity is even. `wr_data_par[b]` must equal the XOR of data byte b, and `wr_be_par` must equal the XOR of the four enable bits. On any mismatch the write is dropped and `par_err` goes to 1 and stays 1 until reset.
- R8: `rd_data_par[b]` equals the XOR of `rd_data` bits 8b+7..8b in every cycle.
- R9: If read and write strobes are high in the same cycle, the write is performed and the read is answered with `rd_valid` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_pulse | input | 1 | One-cycle configuration read strobe |
| wr_pulse | input | 1 | One-cycle configuration write strobe |
| reg_num | input | 10 | Register number, valid with either strobe |
| func_num | input | 8 | Function number, valid with either strobe |
| wr_data | input | 32 | Write data |
| wr_data_par | input | 4 | Even parity per write data byte |
| wr_be | input | 4 | Write byte enables |
| wr_be_par | input | 1 | Even parity over the byte enables |
| rd_data | output | 32 | Read response data, zero when not valid |
| rd_data_par | output | 4 | Even parity per read data byte |
| rd_valid | output | 1 | Register owned; read response valid |
| par_err | output | 1 | Sticky write parity error flag |

## Verification
The bench builds the block with BASE = 1020 and NREGS = 4, so the window ends at the largest 10-bit register number, 1023. This places both window edges in reach: 1019 just below the window and 1023 at its top. It also exercises the range compare where BASE+NREGS no longer fits in 10 bits. With only four registers, every register can be read back after reset and after each write pattern.

// File: rtl/cfg_snoop_regs.sv
module cfg_snoop_regs #(
  parameter int BASE  = 64,
  parameter int NREGS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_pulse,
  input  logic        wr_pulse,
  input  logic [9:0]  reg_num,
  input  logic [7:0]  func_num,
  input  logic [31:0] wr_data,
  input  logic [3:0]  wr_data_par,
  input  logic [3:0]  wr_be,
  input  logic        wr_be_par,
  output logic [31:0] rd_data,
  output logic [3:0]  rd_data_par,
  output logic        rd_valid,
  output logic        par_err
);
  localparam int IW   = NREGS > 1 ? $clog2(NREGS) : 1;
  localparam int LAST = BASE + NREGS - 1;

  logic [31:0]   regs [NREGS];
  logic [IW-1:0] idx;
  logic          hit, data_ok, be_ok, wr_ok;

  assign idx   = IW'(reg_num - 10'(BASE));
  assign hit   = (func_num == 8'd0) && (int'(reg_num) >= BASE) && (int'(reg_num) <= LAST);
  assign be_ok = (^wr_be) == wr_be_par;
  assign wr_ok = data_ok && be_ok;

  always_comb begin
    data_ok = 1'b1;
    for (int b = 0; b < 4; b++)
      if ((^wr_data[8*b +: 8]) != wr_data_par[b]) data_ok = 1'b0;
  end

  always_comb
    for (int b = 0; b < 4; b++) rd_data_par[b] = ^rd_data[8*b +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      par_err  <= 1'b0;
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      if (wr_pulse && !wr_ok) par_err <= 1'b1;
      if (wr_pulse && wr_ok && hit)
        for (int b = 0; b < 4; b++)
          if (wr_be[b]) regs[idx][8*b +: 8] <= wr_data[8*b +: 8];
      if (rd_pulse && !wr_pulse && hit) begin
        rd_valid <= 1'b1;
        rd_data  <= regs[idx];
      end
    end
  end
endmodule

// File: rtl/cfg_snoop_regs_chk.sv
module cfg_snoop_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_pulse,
  input logic        wr_pulse,
  input logic [7:0]  func_num,
  input logic [31:0] rd_data,
  input logic        rd_valid,
  input logic        par_err
);
  // R3
  valid_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(rd_pulse) && !$past(wr_pulse)));

  // R3
  valid_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_pulse) |=> !rd_valid);

  // R3
  data_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == 32'd0));

  // R4
  other_func_unclaimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse && func_num != 8'd0) |=> !rd_valid);

  // R7
  par_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> par_err);

  // R9
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse && wr_pulse) |=> !rd_valid);
endmodule

bind cfg_snoop_regs cfg_snoop_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_pulse(rd_pulse), .wr_pulse(wr_pulse),
  .func_num(func_num), .rd_data(rd_data), .rd_valid(rd_valid), .par_err(par_err)
);

// File: tb/cfg_snoop_regs_tb.sv
module cfg_snoop_regs_tb;
  localparam int BASE  = 1020;
  localparam int NREGS = 4;

  logic clk = 1'b0, rst_n = 1'b0, rd_pulse = 1'b0, wr_pulse = 1'b0;
  logic [9:0]  reg_num = '0;
  logic [7:0]  func_num = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_data_par = '0, wr_be = '0;
  logic        wr_be_par = 1'b0;
  logic [31:0] rd_data;
  logic [3:0]  rd_data_par;
  logic        rd_valid, par_err;

  int nchk = 0, nerr = 0;
  logic [31:0] mdl [NREGS];

  always #5 clk = ~clk;

  cfg_snoop_regs #(.BASE(BASE), .NREGS(NREGS)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_pulse(rd_pulse), .wr_pulse(wr_pulse),
    .reg_num(reg_num), .func_num(func_num), .wr_data(wr_data),
    .wr_data_par(wr_data_par), .wr_be(wr_be), .wr_be_par(wr_be_par),
    .rd_data(rd_data), .rd_data_par(rd_data_par), .rd_valid(rd_valid),
    .par_err(par_err)
  );

  function automatic logic [3:0] bpar(input logic [31:0] d);
    return {^d[31:24], ^d[23:16], ^d[15:8], ^d[7:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit owns(input logic [9:0] r, input logic [7:0] f);
    return f == 8'd0 && int'(r) >= BASE && int'(r) < BASE + NREGS;
  endfunction

  task automatic do_write(input logic [9:0] r, input logic [7:0] f, input logic [31:0] d,
                          input logic [3:0] be, input bit bad_d, input bit bad_be,
                          input bit with_read);
    @(negedge clk);
    reg_num = r; func_num = f; wr_data = d; wr_be = be;
    wr_data_par = bpar(d) ^ {3'b000, bad_d};
    wr_be_par = (^be) ^ bad_be;
    wr_pulse = 1'b1; rd_pulse = with_read;
    @(negedge clk);
    wr_pulse = 1'b0; rd_pulse = 1'b0;
    if (with_read) check("R9 valid low on collision", 32'(rd_valid), 32'd0);
    if (!bad_d && !bad_be && owns(r, f))
      for (int b = 0; b < 4; b++)
        if (be[b]) mdl[int'(r) - BASE][8*b +: 8] = d[8*b +: 8];
  endtask

  task automatic do_read(input logic [9:0] r, input logic [7:0] f, input string req);
    logic own;
    logic [31:0] exp;
    own = owns(r, f);
    exp = own ? mdl[int'(r) - BASE] : 32'd0;
    @(negedge clk);
    reg_num = r; func_num = f; rd_pulse = 1'b1;
    check({req, " no early valid"}, 32'(rd_valid), 32'd0);
    @(negedge clk);
    rd_pulse = 1'b0;
    check({req, " valid"}, 32'(rd_valid), 32'(own));
    check({req, " data"}, rd_data, exp);
    check("R8 data parity", 32'(rd_data_par), 32'(bpar(exp)));
    @(negedge clk);
    check("R3 valid drops", 32'(rd_valid), 32'd0);
    check("R3 data drops", rd_data, 32'd0);
  endtask

  task automatic t_reset;
    check("R1 valid", 32'(rd_valid), 32'd0);
    check("R1 data", rd_data, 32'd0);
    check("R1 par_err", 32'(par_err), 32'd0);
    for (int i = 0; i < NREGS; i++) do_read(10'(BASE + i), 8'd0, "R1 readback");
  endtask

  task automatic t_full_write;
    do_write(10'd1020, 8'd0, 32'hDEADBEEF, 4'hF, 0, 0, 0);
    do_write(10'd1023, 8'd0, 32'h0123_4567, 4'hF, 0, 0, 0);
    do_read(10'd1020, 8'd0, "R2 low edge");
    do_read(10'd1023, 8'd0, "R2 top edge");
  endtask

  task automatic t_bytes;
    do_write(10'd1021, 8'd0, 32'hFFFF_FFFF, 4'hF, 0, 0, 0);
    do_write(10'd1021, 8'd0, 32'h1122_3344, 4'b0101, 0, 0, 0);
    do_read(10'd1021, 8'd0, "R5 bytes 0,2");
    do_write(10'd1021, 8'd0, 32'hA5A5_A5A5, 4'b1000, 0, 0, 0);
    do_read(10'd1021, 8'd0, "R5 byte 3");
    do_write(10'd1021, 8'd0, 32'h0000_0000, 4'b0000, 0, 0, 0);
    do_read(10'd1021, 8'd0, "R5 no enables");
  endtask

  task automatic t_outside;
    do_write(10'd1019, 8'd0, 32'h5555_0000, 4'hF, 0, 0, 0);
    do_write(10'd1022, 8'd3, 32'h7777_7777, 4'hF, 0, 0, 0);
    do_write(10'd4,    8'd0, 32'h9999_9999, 4'hF, 0, 0, 0);
    for (int i = 0; i < NREGS; i++) do_read(10'(BASE + i), 8'd0, "R6 regs unchanged");
    do_read(10'd1019, 8'd0, "R4 below window");
    do_read(10'd0,    8'd0, "R4 register 0");
    do_read(10'd1020, 8'd1, "R4 other function");
  endtask

  task automatic t_parity;
    check("R7 flag clear before", 32'(par_err), 32'd0);
    do_write(10'd1022, 8'd0, 32'hCAFE_F00D, 4'hF, 1, 0, 0);
    check("R7 flag after data error", 32'(par_err), 32'd1);
    do_read(10'd1022, 8'd0, "R7 data-bad write dropped");
    do_write(10'd1022, 8'd0, 32'hCAFE_F00D, 4'h3, 0, 1, 0);
    do_read(10'd1022, 8'd0, "R7 be-bad write dropped");
    do_write(10'd1022, 8'd0, 32'hCAFE_F00D, 4'hF, 0, 0, 0);
    do_read(10'd1022, 8'd0, "R7 good write after error");
    check("R7 flag sticky", 32'(par_err), 32'd1);
  endtask

  task automatic t_collide;
    do_write(10'd1023, 8'd0, 32'h8000_0001, 4'hF, 0, 0, 1);
    do_read(10'd1023, 8'd0, "R9 write performed");
  endtask

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREGS; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_full_write;
    t_bytes;
    t_outside;
    t_collide;
    t_parity;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule